// File: doc/BRIEF.md
# Banked Nibble Real-Time Clock

This block is a real-time clock with a 4-bit data path behind sixteen addresses. A two-bit bank field in a control register picks what the low thirteen addresses (0x0 to 0xC) show. Bank 0 shows the BCD time and calendar digits. Bank 1 shows the alarm nibbles, the hour-format select and the leap-year counter. Banks 2 and 3 are two independent 13-nibble scratch memories. The three top addresses hold the control, test and reset-command registers, and they can be reached from every bank.

The block counts in whole seconds. A clock-enable input `tick` supplies the time base, and an internal prescaler turns every `TICKS_PER_SEC` ticks into one second step. From there the carry ripples through seconds, minutes, hours, day-of-week, day, month and year. The hours run in 24-hour or 12-hour form, and the day length follows the month and a two-bit leap-year counter. A run bit in the control register stops counting so that software can read or load a coherent time. Seconds that arrive while counting is stopped are lost.

Top module: `nibble_rtc`

## Requirements
- R1: After the synchronous reset the control register reads 0 (bank 0, alarm off, counting stopped). Time reads 00:00:00 in 24-hour format, day-of-week 0, day 01, month 01, year 00, and the leap-year counter reads 0.
- R2: `rd_data` is DATA_W bits wide. Bits DATA_W-1:4 always read zero, and a read is combinational on `addr` and the selected bank.
- R3: Address 0xD is the control register in every bank. Bits 1:0 select the bank (0 time, 1 alarm/format, 2 RAM A, 3 RAM B), bit 2 is alarm enable and bit 3 is run. Addresses 0xE and 0xF read zero.
- R4: In bank 0, addresses 0x0 to 0xC are, in order: seconds ones, seconds tens, minutes ones, minutes tens, hours ones, hours tens, day-of-week, day ones, day tens, month ones, month tens, year ones, year tens. Each digit is writable.
- R5: With run set, one second elapses per TICKS_PER_SEC cycles of `tick`. Seconds and minutes wrap 59 to 00. In 24-hour format hours wrap 23 to 00. Day-of-week steps 6 to 0 at midnight.
- R6: The day wraps to 01 past the month length: 30 for months 4, 6, 9 and 11, 29 for month 2 when the leap counter is 0, 28 for month 2 otherwise, and 31 for the rest. Month wraps 12 to 01 and year 99 to 00. The leap counter (bank 1, address 0xB, bits 1:0) increments modulo 4 on each year wrap.
- R7: Bank 1 address 0xA bit 0 selects 12-hour (0) or 24-hour (1) format. In 12-hour format the hours count 12, 1 ... 11, and hours-tens bit 1 is PM. Going from 11:59:59 to 12:00:00 toggles PM, and the day advances only when PM goes from 1 to 0.
- R8: While run is 0 the time digits do not change except by host writes. Seconds that elapse meanwhile are dropped, not applied later.
- R9: Banks 2 and 3 each store 13 nibbles at 0x0 to 0xC. A read returns the last value written to that bank and address, with no effect on the other bank or on the time.
- R10: Bank 1 addresses 0x2 to 0x8 are readable alarm nibbles. Writing address 0xF with bit 0 set clears all of them and leaves the format and leap-counter fields unchanged.
- R11: Writing address 0xF with bit 1 set restarts the prescaler, so the next second step comes a full TICKS_PER_SEC ticks later.
- R12: A host write to a time digit in the same cycle as a second step wins for that digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, TICKS_PER_SEC per second |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, takes effect at the clock edge |
| wr_data | input | 4 | Write nibble |
| rd_data | output | DATA_W | Read data, upper bits zero |

## Verification
The embedded properties assume the host writes only through `wr_en` with a 4-bit nibble, and that `TICKS_PER_SEC` is at least 2 so that a prescaler restart cannot coincide with a second step. The RAM property assumes writes into a RAM bank use addresses 0x0 to 0xC, which the top-level decode guarantees. The bench loads only legal BCD calendar values before it lets time run. It drives `tick` only in bursts that start right after a prescaler restart, so every run has a known number of seconds. Random times are biased toward the end of minutes, hours, months and years so that the long carry chains occur often.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NDIG = 13;
    localparam int NALM = 7;

    localparam logic [3:0] ADR_SEC_O  = 4'h0;
    localparam logic [3:0] ADR_SEC_T  = 4'h1;
    localparam logic [3:0] ADR_MIN_O  = 4'h2;
    localparam logic [3:0] ADR_MIN_T  = 4'h3;
    localparam logic [3:0] ADR_HR_O   = 4'h4;
    localparam logic [3:0] ADR_HR_T   = 4'h5;
    localparam logic [3:0] ADR_DOW    = 4'h6;
    localparam logic [3:0] ADR_DAY_O  = 4'h7;
    localparam logic [3:0] ADR_DAY_T  = 4'h8;
    localparam logic [3:0] ADR_MON_O  = 4'h9;
    localparam logic [3:0] ADR_MON_T  = 4'hA;
    localparam logic [3:0] ADR_YR_O   = 4'hB;
    localparam logic [3:0] ADR_YR_T   = 4'hC;
    localparam logic [3:0] ADR_CTL    = 4'hD;
    localparam logic [3:0] ADR_CMD    = 4'hF;
    localparam logic [3:0] ADR_FMT    = 4'hA;
    localparam logic [3:0] ADR_LEAP   = 4'hB;
    localparam logic [3:0] ADR_ALM_LO = 4'h2;
    localparam logic [3:0] ADR_ALM_HI = 4'h8;

    typedef enum logic [1:0] {
        BANK_TIME  = 2'd0,
        BANK_CFG   = 2'd1,
        BANK_RAM_A = 2'd2,
        BANK_RAM_B = 2'd3
    } bank_e;

    // bit 3 run, bit 2 alarm enable, bits 1:0 bank
    typedef struct packed {
        logic  run;
        logic  alarm_on;
        bank_e bank;
    } ctl_t;

    function automatic logic [6:0] bcd_to_bin(input logic [3:0] tens, input logic [3:0] ones);
        return 7'(tens) * 7'd10 + 7'(ones);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        return {4'(v / 7'd10), 4'(v % 7'd10)};
    endfunction

    function automatic logic [4:0] month_len(input logic [6:0] month, input logic leap);
        case (month)
            7'd2:                       return leap ? 5'd29 : 5'd28;
            7'd4, 7'd6, 7'd9, 7'd11:    return 5'd30;
            default:                    return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assign sec_pulse = tick && !restart && (cnt == LAST);

    generate
        if (TICKS_PER_SEC > 1) begin : g_chk
            // a restart pushes the next step at least one tick away
            p_restart_quiet_r11: assert property (@(posedge clk) disable iff (rst)
                restart |=> !sec_pulse);
        end
    endgenerate

endmodule

// File: rtl/rtc_nibble_ram.sv
module rtc_nibble_ram #(
    parameter int DEPTH = 13
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [3:0]               wdata,
    output logic [3:0]               rdata
);
    logic [3:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    assign rdata = (32'(addr) < DEPTH) ? mem[addr] : 4'h0;

    p_store_r9: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_pulse,
    input  logic       run,
    input  logic       wr_time,
    input  logic       wr_cfg,
    input  logic       alarm_clr,
    input  logic [3:0] addr,
    input  logic [3:0] wdata,
    output logic [3:0] time_rd,
    output logic [3:0] cfg_rd
);
    logic [NDIG-1:0][3:0] tdig, tdig_n;
    logic [NALM-1:0][3:0] alm;
    logic                 fmt24;
    logic [1:0]           leap, leap_n;

    logic [6:0] sec_b, min_b, hr_b, day_b, mon_b, yr_b, nv;
    logic       step, c_min, c_hr, c_day, c_mon, c_yr, pm_n;
    logic [4:0] dim;
    logic [2:0] alm_idx;
    logic       alm_hit, leap_wr;

    assign step    = sec_pulse && run;
    assign alm_idx = 3'(addr - ADR_ALM_LO);
    assign alm_hit = (addr >= ADR_ALM_LO) && (addr <= ADR_ALM_HI);
    assign leap_wr = wr_cfg && (addr == ADR_LEAP);

    always_comb begin
        tdig_n = tdig;
        leap_n = leap;
        nv     = '0;
        pm_n   = tdig[ADR_HR_T][1];
        sec_b  = bcd_to_bin(tdig[ADR_SEC_T], tdig[ADR_SEC_O]);
        min_b  = bcd_to_bin(tdig[ADR_MIN_T], tdig[ADR_MIN_O]);
        hr_b   = fmt24 ? bcd_to_bin(tdig[ADR_HR_T], tdig[ADR_HR_O])
                       : bcd_to_bin({3'b000, tdig[ADR_HR_T][0]}, tdig[ADR_HR_O]);
        day_b  = bcd_to_bin(tdig[ADR_DAY_T], tdig[ADR_DAY_O]);
        mon_b  = bcd_to_bin(tdig[ADR_MON_T], tdig[ADR_MON_O]);
        yr_b   = bcd_to_bin(tdig[ADR_YR_T], tdig[ADR_YR_O]);
        dim    = month_len(mon_b, leap == 2'd0);

        c_min = step && (sec_b >= 7'd59);
        c_hr  = c_min && (min_b >= 7'd59);
        c_day = fmt24 ? (c_hr && hr_b >= 7'd23)
                      : (c_hr && hr_b == 7'd11 && tdig[ADR_HR_T][1]);
        c_mon = c_day && (day_b >= 7'(dim));
        c_yr  = c_mon && (mon_b >= 7'd12);

        if (step)
            {tdig_n[ADR_SEC_T], tdig_n[ADR_SEC_O]} = bin_to_bcd(c_min ? 7'd0 : sec_b + 7'd1);
        if (c_min)
            {tdig_n[ADR_MIN_T], tdig_n[ADR_MIN_O]} = bin_to_bcd(c_hr ? 7'd0 : min_b + 7'd1);
        if (c_hr) begin
            if (fmt24) begin
                {tdig_n[ADR_HR_T], tdig_n[ADR_HR_O]} = bin_to_bcd(c_day ? 7'd0 : hr_b + 7'd1);
            end else begin
                if (hr_b == 7'd11) begin
                    nv   = 7'd12;
                    pm_n = ~pm_n;
                end else if (hr_b >= 7'd12) begin
                    nv = 7'd1;
                end else begin
                    nv = hr_b + 7'd1;
                end
                tdig_n[ADR_HR_O] = 4'(nv % 7'd10);
                tdig_n[ADR_HR_T] = {2'b00, pm_n, nv >= 7'd10};
            end
        end
        if (c_day) begin
            tdig_n[ADR_DOW] = (tdig[ADR_DOW] >= 4'd6) ? 4'd0 : tdig[ADR_DOW] + 4'd1;
            {tdig_n[ADR_DAY_T], tdig_n[ADR_DAY_O]} = bin_to_bcd(c_mon ? 7'd1 : day_b + 7'd1);
        end
        if (c_mon)
            {tdig_n[ADR_MON_T], tdig_n[ADR_MON_O]} = bin_to_bcd(c_yr ? 7'd1 : mon_b + 7'd1);
        if (c_yr) begin
            {tdig_n[ADR_YR_T], tdig_n[ADR_YR_O]} = bin_to_bcd((yr_b >= 7'd99) ? 7'd0 : yr_b + 7'd1);
            leap_n = leap + 2'd1;
        end

        // host write overrides the count for the addressed field
        if (wr_time && (32'(addr) < NDIG))
            tdig_n[addr] = wdata;
        if (leap_wr)
            leap_n = wdata[1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tdig            <= '0;
            tdig[ADR_DAY_O] <= 4'd1;
            tdig[ADR_MON_O] <= 4'd1;
            alm             <= '0;
            fmt24           <= 1'b1;
            leap            <= 2'd0;
        end else begin
            tdig <= tdig_n;
            leap <= leap_n;
            if (wr_cfg && addr == ADR_FMT)
                fmt24 <= wdata[0];
            if (alarm_clr)
                alm <= '0;
            else if (wr_cfg && alm_hit)
                alm[alm_idx] <= wdata;
        end
    end

    assign time_rd = (32'(addr) < NDIG) ? tdig[addr] : 4'h0;

    always_comb begin
        if (alm_hit)
            cfg_rd = alm[alm_idx];
        else if (addr == ADR_FMT)
            cfg_rd = {3'b000, fmt24};
        else if (addr == ADR_LEAP)
            cfg_rd = {2'b00, leap};
        else
            cfg_rd = 4'h0;
    end

    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_time) |=> $stable(tdig));

    p_sec_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_time && tdig[ADR_SEC_T] == 4'd5 && tdig[ADR_SEC_O] == 4'd9)
        |=> (tdig[ADR_SEC_T] == 4'd0 && tdig[ADR_SEC_O] == 4'd0));

    p_alarm_clear_r10: assert property (@(posedge clk) disable iff (rst)
        alarm_clr |=> (alm == '0));

    p_leap_step_r6: assert property (@(posedge clk) disable iff (rst)
        (c_yr && !leap_wr) |=> (leap == $past(leap) + 2'd1));

endmodule

// File: rtl/nibble_rtc.sv
module nibble_rtc
    import rtc_pkg::*;
#(
    parameter int TICKS_PER_SEC = 4,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [3:0]        addr,
    input  logic              wr_en,
    input  logic [3:0]        wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NRAM = 2;

    ctl_t       ctl;
    logic       low_adr, wr_time, wr_cfg, cmd_wr, sec_pulse;
    logic [3:0] time_rd, cfg_rd, nib;
    logic [3:0] ram_rd [NRAM];

    assign low_adr = 32'(addr) < NDIG;
    assign wr_time = wr_en && low_adr && (ctl.bank == BANK_TIME);
    assign wr_cfg  = wr_en && low_adr && (ctl.bank == BANK_CFG);
    assign cmd_wr  = wr_en && (addr == ADR_CMD);

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_en && addr == ADR_CTL)
            ctl <= ctl_t'(wr_data);
    end

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .restart   (cmd_wr && wr_data[1]),
        .sec_pulse (sec_pulse)
    );

    rtc_timekeeper u_time (
        .clk       (clk),
        .rst       (rst),
        .sec_pulse (sec_pulse),
        .run       (ctl.run),
        .wr_time   (wr_time),
        .wr_cfg    (wr_cfg),
        .alarm_clr (cmd_wr && wr_data[0]),
        .addr      (addr),
        .wdata     (wr_data),
        .time_rd   (time_rd),
        .cfg_rd    (cfg_rd)
    );

    generate
        for (genvar g = 0; g < NRAM; g++) begin : g_ram
            rtc_nibble_ram #(.DEPTH(NDIG)) u_ram (
                .clk   (clk),
                .rst   (rst),
                .we    (wr_en && low_adr && (ctl.bank == bank_e'(g + 2))),
                .addr  (addr),
                .wdata (wr_data),
                .rdata (ram_rd[g])
            );
        end
    endgenerate

    always_comb begin
        nib = 4'h0;
        if (addr == ADR_CTL)
            nib = ctl;
        else if (low_adr) begin
            case (ctl.bank)
                BANK_TIME:  nib = time_rd;
                BANK_CFG:   nib = cfg_rd;
                BANK_RAM_A: nib = ram_rd[0];
                BANK_RAM_B: nib = ram_rd[1];
                default:    nib = 4'h0;
            endcase
        end
    end

    assign rd_data = DATA_W'(nib);

    p_ctl_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_CTL) |=> (ctl == ctl_t'($past(wr_data))));

endmodule

// File: tb/sim_nibble_rtc.sv
module sim_nibble_rtc;
    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [3:0] addr = 4'h0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    int m_sec, m_min, m_hr, m_dow, m_day, m_mon, m_yr, m_leap;
    bit m_24, m_pm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nibble_rtc #(.TICKS_PER_SEC(TPS), .DATA_W(8)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rd_data;
    endtask

    function automatic int mlen(input int mon, input int leap);
        if (mon == 2) return (leap == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [3:0] exp_dig(input int i);
        case (i)
            0: return 4'(m_sec % 10);
            1: return 4'(m_sec / 10);
            2: return 4'(m_min % 10);
            3: return 4'(m_min / 10);
            4: return 4'(m_hr % 10);
            5: return m_24 ? 4'(m_hr / 10) : 4'((m_pm ? 2 : 0) + m_hr / 10);
            6: return 4'(m_dow);
            7: return 4'(m_day % 10);
            8: return 4'(m_day / 10);
            9: return 4'(m_mon % 10);
            10: return 4'(m_mon / 10);
            11: return 4'(m_yr % 10);
            default: return 4'(m_yr / 10);
        endcase
    endfunction

    function automatic void model_step();
        bit dayc = 0;
        m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0;
        if (m_24) begin
            m_hr++;
            if (m_hr == 24) begin m_hr = 0; dayc = 1; end
        end else begin
            if (m_hr == 11) begin
                m_hr = 12; m_pm = !m_pm;
                if (!m_pm) dayc = 1;
            end else if (m_hr == 12) m_hr = 1;
            else m_hr++;
        end
        if (!dayc) return;
        m_dow = (m_dow == 6) ? 0 : m_dow + 1;
        m_day++;
        if (m_day <= mlen(m_mon, m_leap)) return;
        m_day = 1; m_mon++;
        if (m_mon <= 12) return;
        m_mon = 1; m_yr = (m_yr == 99) ? 0 : m_yr + 1;
        m_leap = (m_leap + 1) % 4;
    endfunction

    // load model into the design, leaves bank 0 with run set
    task automatic load_time();
        wr(4'hD, 4'b0001);
        wr(4'hA, {3'b000, m_24});
        wr(4'hB, 4'(m_leap));
        wr(4'hD, 4'b0000);
        for (int i = 0; i < 13; i++) wr(4'(i), exp_dig(i));
        wr(4'hD, 4'b1000);
    endtask

    task automatic check_time(input string req);
        logic [7:0] v;
        for (int i = 0; i < 13; i++) begin
            rd(4'(i), v);
            chk(req, int'(v), int'(exp_dig(i)));
        end
        wr(4'hD, 4'b1001);
        rd(4'hB, v);
        chk({req, " leap"}, int'(v), m_leap);
        wr(4'hD, 4'b1000);
    endtask

    // restart prescaler then supply exactly n seconds of ticks
    task automatic run_secs(input int n, input bit upd);
        wr(4'hF, 4'b0010);
        tick = 1'b1;
        repeat (TPS * n) @(negedge clk);
        tick = 1'b0;
        if (upd) for (int k = 0; k < n; k++) model_step();
    endtask

    task automatic set_model(input int h24, input int hr, input int pm, input int mi, input int s,
                             input int dw, input int d, input int mo, input int y, input int lp);
        m_24 = h24[0]; m_hr = hr; m_pm = pm[0]; m_min = mi; m_sec = s;
        m_dow = dw; m_day = d; m_mon = mo; m_yr = y; m_leap = lp;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [3:0] ra [13];
        logic [3:0] rb [13];
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 upper bits zero
        rd(4'hD, v); chk("R1 ctl", int'(v), 0);
        set_model(1, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        check_time("R1 reset time");
        wr(4'hD, 4'b0001);
        rd(4'hA, v); chk("R1 fmt24", int'(v), 1);
        wr(4'hD, 4'b0000);
        rd(4'h9, v); chk("R2 upper zero", int'(v[7:4]), 0);

        // R5 R6 full rollover into a new year, leap 3 -> 0
        set_model(1, 23, 0, 59, 58, 6, 31, 12, 99, 3);
        load_time();
        run_secs(2, 1);
        chk("R6 year wrap", m_yr * 100 + m_mon * 10 + m_day, 11);
        check_time("R5 R6 new year");

        // R6 February with leap counter 0 and 1
        set_model(1, 23, 0, 59, 59, 2, 28, 2, 24, 0);
        load_time(); run_secs(1, 1);
        chk("R6 feb leap day", m_day, 29);
        check_time("R6 feb29");
        set_model(1, 23, 0, 59, 59, 2, 28, 2, 25, 1);
        load_time(); run_secs(1, 1);
        check_time("R6 mar1");
        set_model(1, 23, 0, 59, 59, 3, 30, 4, 25, 1);
        load_time(); run_secs(1, 1);
        check_time("R6 30-day month");

        // R7 twelve-hour transitions
        set_model(0, 11, 0, 59, 59, 1, 5, 6, 30, 2);
        load_time(); run_secs(1, 1);
        chk("R7 noon pm", int'(m_pm), 1);
        check_time("R7 am to pm");
        set_model(0, 11, 1, 59, 59, 1, 5, 6, 30, 2);
        load_time(); run_secs(1, 1);
        check_time("R7 pm to am next day");
        set_model(0, 12, 1, 59, 59, 1, 5, 6, 30, 2);
        load_time(); run_secs(1, 1);
        check_time("R7 12 to 1");

        // R8 stopped counting, dropped seconds
        set_model(1, 10, 0, 20, 30, 4, 15, 7, 40, 0);
        load_time();
        wr(4'hD, 4'b0000);
        run_secs(3, 0);
        check_time("R8 frozen");
        run_secs(1, 1);
        check_time("R8 resumes without backlog");

        // R11 prescaler restart
        set_model(1, 0, 0, 0, 0, 0, 1, 1, 0, 0);
        load_time();
        @(negedge clk); tick = 1'b1;
        repeat (2) @(negedge clk);
        tick = 1'b0;
        wr(4'hF, 4'b0010);
        tick = 1'b1;
        repeat (TPS - 1) @(negedge clk);
        tick = 1'b0;
        rd(4'h0, v); chk("R11 no early step", int'(v), 0);
        tick = 1'b1; @(negedge clk); tick = 1'b0;
        rd(4'h0, v); chk("R11 step after full period", int'(v), 1);

        // R12 write wins over a same-cycle step (05 -> would be 06)
        set_model(1, 0, 0, 0, 5, 0, 1, 1, 0, 0);
        load_time();
        wr(4'hF, 4'b0010);
        tick = 1'b1;
        repeat (TPS - 1) @(negedge clk);
        addr = 4'h0; wr_data = 4'h2; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(4'h0, v); chk("R12 write priority", int'(v), 2);
        rd(4'h1, v); chk("R12 tens", int'(v), 0);

        // R9 RAM banks, R3 control visible in every bank
        wr(4'hD, 4'b0010);
        for (int i = 0; i < 13; i++) begin ra[i] = 4'($urandom); wr(4'(i), ra[i]); end
        wr(4'hD, 4'b0011);
        for (int i = 0; i < 13; i++) begin rb[i] = ~ra[i]; wr(4'(i), rb[i]); end
        rd(4'hD, v); chk("R3 ctl in bank3", int'(v), 3);
        rd(4'hE, v); chk("R3 test reads 0", int'(v), 0);
        rd(4'hF, v); chk("R3 cmd reads 0", int'(v), 0);
        for (int i = 0; i < 13; i++) begin rd(4'(i), v); chk("R9 ram B", int'(v), int'(rb[i])); end
        wr(4'hD, 4'b0010);
        rd(4'hD, v); chk("R3 ctl in bank2", int'(v), 2);
        for (int i = 0; i < 13; i++) begin rd(4'(i), v); chk("R9 ram A", int'(v), int'(ra[i])); end
        wr(4'hD, 4'b0000);
        rd(4'h0, v); chk("R9 time untouched", int'(v), 2);
        rd(4'h4, v); chk("R4 hours ones", int'(v), 0);

        // R10 alarm nibbles and clear
        wr(4'hD, 4'b0101);
        rd(4'hD, v); chk("R3 alarm bit", int'(v), 5);
        for (int i = 2; i <= 8; i++) wr(4'(i), 4'(i + 7));
        rd(4'h5, v); chk("R10 alarm store", int'(v), 12);
        wr(4'hF, 4'b0001);
        for (int i = 2; i <= 8; i++) begin rd(4'(i), v); chk("R10 alarm cleared", int'(v), 0); end
        rd(4'hA, v); chk("R10 fmt kept", int'(v), 1);

        // random biased times
        for (int it = 0; it < 12; it++) begin
            int mo, d, h24, hr, pm, n;
            mo  = $urandom_range(12, 1);
            d   = ($urandom_range(1, 0) == 1) ? mlen(mo, 1) : $urandom_range(28, 1);
            h24 = $urandom_range(1, 0);
            hr  = h24 ? (($urandom_range(1, 0) == 1) ? 23 : $urandom_range(22, 0))
                      : $urandom_range(12, 11);
            pm  = $urandom_range(1, 0);
            set_model(h24, hr, pm, $urandom_range(59, 58), $urandom_range(59, 55),
                      $urandom_range(6, 0), d, mo, $urandom_range(99, 97), $urandom_range(3, 0));
            load_time();
            n = $urandom_range(5, 1);
            run_secs(n, 1);
            check_time("R5 R6 R7 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule